// File: doc/BRIEF.md
# Speed-Hold Mode Sequencer

This block keeps track of which operating mode a vehicle speed-hold function is in, and it drives the command lines of the functions that do the regulating. Seven single-cycle event inputs come from the driver controls and the speed loop: enable, disable, start-increase, stop-increase, brake, resume and speed-reached. The block moves between five modes: idle, maintain, increase, interrupted and resume.

On each transition, the block issues registered commands. A one-cycle pulse tells the speed sensor to latch the current rotation rate. Three level enables switch on the constant-speed, acceleration and return-to-previous-speed functions. Measuring speed, driving the throttle and closing the control loop are all outside this block. A 3-bit status output shows the current mode.

Several events can arrive in the same cycle. When that happens, a fixed priority picks exactly one of them. The other events asserted in that cycle are discarded.

Top module: `speed_hold_ctrl`

## Requirements
- R1: A synchronous active-high `rst`, sampled at a rising edge, sets `mode_o` to 0 after that edge. It also drives all three enables low and holds `rate_latch_o` low. Reset wins over any event asserted in the same cycle.
- R2: Mode codes on `mode_o` are idle 0, maintain 1, increase 2, interrupted 3 and resume 4. `hold_en_o` is high exactly in mode 1, `raise_en_o` exactly in mode 2, and `return_en_o` exactly in mode 4. In every mode, at most one enable is high.
- R3: In idle, enable moves to maintain. Every other event leaves the mode unchanged.
- R4: In maintain, the transitions are:
  - disable moves to idle;
  - start-increase moves to increase;
  - brake moves to interrupted;
  - stop-increase, resume, enable and speed-reached are ignored.
- R5: In increase, stop-increase moves back to maintain. Both disable and brake move to interrupted, not to idle. Start-increase, resume, enable and speed-reached are ignored.
- R6: In interrupted, resume moves to resume and disable moves to idle. All other events are ignored.
- R7: In resume, disable or brake moves to interrupted and speed-reached moves to maintain. All other events are ignored.
- R8: `rate_latch_o` is high for exactly the one cycle after the edge that takes idle to maintain through enable, or increase to maintain through stop-increase. It is low after every other edge.
- R9: When several events are asserted together, only the highest one in the order brake, disable, speed-reached, stop-increase, start-increase, resume, enable is acted on. This holds even when the winning event is a no-op in the current mode.
- R10: All outputs are registered and change only at the edge that samples the event. With no event asserted, the mode and the enables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_enable | input | 1 | Enable event |
| ev_disable | input | 1 | Disable event |
| ev_start_inc | input | 1 | Start-increase event |
| ev_stop_inc | input | 1 | Stop-increase event |
| ev_brake | input | 1 | Brake event |
| ev_resume | input | 1 | Resume event |
| ev_speed_reached | input | 1 | Target speed reached event |
| rate_latch_o | output | 1 | One-cycle pulse: record rotation rate |
| hold_en_o | output | 1 | Constant-speed function enable |
| raise_en_o | output | 1 | Speed-increase function enable |
| return_en_o | output | 1 | Return-to-previous-speed enable |
| mode_o | output | 3 | Current mode code |

## Verification
The bench builds the block with its default parameters: seven events and a 3-bit mode code. Those are the only values the mode table supports, so every one of the 35 mode/event pairs can be reached.

The bench steers the block into each mode and then applies each single event. It compares the next mode, the pulse and the enables against a reference model written from the transition rules. The pulse is checked again one cycle later, to confirm it lasts only one cycle.

A scripted sequence covers two further areas. The first is simultaneous events, including a winner that is a no-op in the current mode. The second is a reset that arrives together with an event.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int NUM_EV = 7;
  localparam int MODE_W = 3;

  // event vector bit positions; lower index = higher priority
  localparam int EV_BRAKE  = 0;
  localparam int EV_DIS    = 1;
  localparam int EV_REACH  = 2;
  localparam int EV_STOP   = 3;
  localparam int EV_START  = 4;
  localparam int EV_RESUME = 5;
  localparam int EV_EN     = 6;

  typedef enum logic [MODE_W-1:0] {
    M_IDLE   = 3'd0,
    M_HOLD   = 3'd1,
    M_RAISE  = 3'd2,
    M_HALTED = 3'd3,
    M_RETURN = 3'd4
  } mode_t;
endpackage

// File: rtl/cc_event_arbiter.sv
module cc_event_arbiter #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // seen[i] is set when any request below index i is present
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
endmodule

// File: rtl/cc_mode_logic.sv
module cc_mode_logic
  import cc_pkg::*;
(
  input  mode_t             cur,
  input  logic [NUM_EV-1:0] grant,
  output mode_t             nxt,
  output logic              latch
);
  always_comb begin
    nxt   = cur;
    latch = 1'b0;
    unique case (cur)
      M_IDLE: begin
        if (grant[EV_EN]) begin
          nxt   = M_HOLD;
          latch = 1'b1;
        end
      end
      M_HOLD: begin
        if (grant[EV_DIS])        nxt = M_IDLE;
        else if (grant[EV_START]) nxt = M_RAISE;
        else if (grant[EV_BRAKE]) nxt = M_HALTED;
      end
      M_RAISE: begin
        if (grant[EV_STOP]) begin
          nxt   = M_HOLD;
          latch = 1'b1;
        end else if (grant[EV_DIS] || grant[EV_BRAKE]) begin
          nxt = M_HALTED;
        end
      end
      M_HALTED: begin
        if (grant[EV_RESUME])   nxt = M_RETURN;
        else if (grant[EV_DIS]) nxt = M_IDLE;
      end
      M_RETURN: begin
        if (grant[EV_DIS] || grant[EV_BRAKE]) nxt = M_HALTED;
        else if (grant[EV_REACH])             nxt = M_HOLD;
      end
      default: nxt = M_IDLE;
    endcase
  end
endmodule

// File: rtl/cc_out_reg.sv
module cc_out_reg
  import cc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t nxt,
  input  logic  latch,
  output mode_t mode_q,
  output logic  latch_q,
  output logic  hold_q,
  output logic  raise_q,
  output logic  return_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_IDLE;
      latch_q  <= 1'b0;
      hold_q   <= 1'b0;
      raise_q  <= 1'b0;
      return_q <= 1'b0;
    end else begin
      mode_q   <= nxt;
      latch_q  <= latch;
      hold_q   <= (nxt == M_HOLD);
      raise_q  <= (nxt == M_RAISE);
      return_q <= (nxt == M_RETURN);
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mode_q == M_IDLE && !latch_q && !hold_q && !raise_q && !return_q));

  assert_enable_match_R2: assert property (@(posedge clk) disable iff (rst)
    latch_q |-> (hold_q && mode_q == M_HOLD));

  assert_raise_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q != M_HOLD && mode_q != M_RAISE) |=> (mode_q != M_RAISE));

  assert_return_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q != M_HALTED && mode_q != M_RETURN) |=> (mode_q != M_RETURN));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    latch_q |=> !latch_q);
endmodule

// File: rtl/speed_hold_ctrl.sv
module speed_hold_ctrl
  import cc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_enable,
  input  logic              ev_disable,
  input  logic              ev_start_inc,
  input  logic              ev_stop_inc,
  input  logic              ev_brake,
  input  logic              ev_resume,
  input  logic              ev_speed_reached,
  output logic              rate_latch_o,
  output logic              hold_en_o,
  output logic              raise_en_o,
  output logic              return_en_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [NUM_EV-1:0] ev_vec;
  logic [NUM_EV-1:0] grant;
  mode_t             cur;
  mode_t             nxt;
  logic              latch;

  always_comb begin
    ev_vec            = '0;
    ev_vec[EV_BRAKE]  = ev_brake;
    ev_vec[EV_DIS]    = ev_disable;
    ev_vec[EV_REACH]  = ev_speed_reached;
    ev_vec[EV_STOP]   = ev_stop_inc;
    ev_vec[EV_START]  = ev_start_inc;
    ev_vec[EV_RESUME] = ev_resume;
    ev_vec[EV_EN]     = ev_enable;
  end

  cc_event_arbiter #(.N(NUM_EV)) arb_i (
    .req   (ev_vec),
    .grant (grant)
  );

  cc_mode_logic logic_i (
    .cur   (cur),
    .grant (grant),
    .nxt   (nxt),
    .latch (latch)
  );

  cc_out_reg reg_i (
    .clk      (clk),
    .rst      (rst),
    .nxt      (nxt),
    .latch    (latch),
    .mode_q   (cur),
    .latch_q  (rate_latch_o),
    .hold_q   (hold_en_o),
    .raise_q  (raise_en_o),
    .return_q (return_en_o)
  );

  assign mode_o = cur;

  assert_single_grant_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_grant_present_R9: assert property (@(posedge clk) disable iff (rst)
    (|ev_vec) |-> (|grant));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ev_vec == '0) |=> ($stable(mode_o) && !rate_latch_o));

  assert_one_enable_R2: assert property (@(posedge clk) disable iff (rst)
    $countones({hold_en_o, raise_en_o, return_en_o}) <= 1);
endmodule

// File: tb/speed_hold_ctrl_tb_top.sv
module speed_hold_ctrl_tb_top;
  // event bits: 6 enable, 5 resume, 4 start, 3 stop, 2 reached, 1 disable, 0 brake
  localparam logic [6:0] E_NO  = 7'b0000000;
  localparam logic [6:0] E_EN  = 7'b1000000;
  localparam logic [6:0] E_RES = 7'b0100000;
  localparam logic [6:0] E_STA = 7'b0010000;
  localparam logic [6:0] E_STO = 7'b0001000;
  localparam logic [6:0] E_RCH = 7'b0000100;
  localparam logic [6:0] E_DIS = 7'b0000010;
  localparam logic [6:0] E_BRK = 7'b0000001;

  localparam int NV = 25;
  // {rst, events, expected mode, expected pulse}
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, E_NO,          3'd0, 1'b0},
    {1'b0, E_EN,          3'd1, 1'b1},
    {1'b0, E_NO,          3'd1, 1'b0},
    {1'b0, E_STA,         3'd2, 1'b0},
    {1'b0, E_STA,         3'd2, 1'b0},
    {1'b0, E_STO,         3'd1, 1'b1},
    {1'b0, E_STA,         3'd2, 1'b0},
    {1'b0, E_DIS,         3'd3, 1'b0},
    {1'b0, E_RCH,         3'd3, 1'b0},
    {1'b0, E_RES,         3'd4, 1'b0},
    {1'b0, E_EN,          3'd4, 1'b0},
    {1'b0, E_RCH,         3'd1, 1'b0},
    {1'b0, E_BRK,         3'd3, 1'b0},
    {1'b0, E_RES,         3'd4, 1'b0},
    {1'b0, E_BRK,         3'd3, 1'b0},
    {1'b0, E_DIS,         3'd0, 1'b0},
    {1'b0, E_RES,         3'd0, 1'b0},
    {1'b0, E_EN | E_BRK,  3'd0, 1'b0},
    {1'b0, E_EN | E_RES,  3'd0, 1'b0},
    {1'b0, E_EN,          3'd1, 1'b1},
    {1'b1, E_EN,          3'd0, 1'b0},
    {1'b0, E_EN,          3'd1, 1'b1},
    {1'b0, E_STA | E_EN,  3'd2, 1'b0},
    {1'b0, E_STO | E_BRK, 3'd3, 1'b0},
    {1'b0, E_RES | E_DIS, 3'd0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] ev  = '0;
  logic       latch, hold_en, raise_en, return_en;
  logic [2:0] mode;
  int         checks = 0;
  int         errors = 0;
  bit         done   = 1'b0;

  always #5 clk = ~clk;

  speed_hold_ctrl dut_i (
    .clk              (clk),
    .rst              (rst),
    .ev_enable        (ev[6]),
    .ev_disable       (ev[1]),
    .ev_start_inc     (ev[4]),
    .ev_stop_inc      (ev[3]),
    .ev_brake         (ev[0]),
    .ev_resume        (ev[5]),
    .ev_speed_reached (ev[2]),
    .rate_latch_o     (latch),
    .hold_en_o        (hold_en),
    .raise_en_o       (raise_en),
    .return_en_o      (return_en),
    .mode_o           (mode)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference model built from the transition rules
  task automatic ref_step(input logic [2:0] m, input logic [6:0] e,
                          output logic [2:0] nm, output logic rec);
    logic [6:0] w;
    w = '0;
    if      (e[0]) w[0] = 1'b1;
    else if (e[1]) w[1] = 1'b1;
    else if (e[2]) w[2] = 1'b1;
    else if (e[3]) w[3] = 1'b1;
    else if (e[4]) w[4] = 1'b1;
    else if (e[5]) w[5] = 1'b1;
    else if (e[6]) w[6] = 1'b1;
    nm = m;
    rec = 1'b0;
    case (m)
      3'd0: if (w[6]) begin nm = 3'd1; rec = 1'b1; end
      3'd1: if (w[1]) nm = 3'd0; else if (w[4]) nm = 3'd2; else if (w[0]) nm = 3'd3;
      3'd2: if (w[3]) begin nm = 3'd1; rec = 1'b1; end
            else if (w[1] || w[0]) nm = 3'd3;
      3'd3: if (w[5]) nm = 3'd4; else if (w[1]) nm = 3'd0;
      3'd4: if (w[1] || w[0]) nm = 3'd3; else if (w[2]) nm = 3'd1;
      default: nm = 3'd0;
    endcase
  endtask

  task automatic step(input logic r, input logic [6:0] e);
    @(negedge clk);
    rst = r;
    ev  = e;
    @(posedge clk);
    #1;
    rst = 1'b0;
    ev  = '0;
  endtask

  task automatic chk_en(input string tag, input logic [2:0] m);
    chk(tag, "enables", int'({return_en, raise_en, hold_en}),
        int'({m == 3'd4, m == 3'd2, m == 3'd1}));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] nm;
    logic       rec;
    step(1'b1, E_NO);
    step(1'b1, E_NO);
    // R1: reset state
    chk("R1", "mode", int'(mode), 0);
    chk("R1", "pulse", int'(latch), 0);
    chk_en("R1", 3'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      step(VEC[i][11], VEC[i][10:4]);
      if (VEC[i][11])                      tag = "R1";
      else if ($countones(VEC[i][10:4]) > 1) tag = "R9";
      else if (VEC[i][10:4] == E_NO)       tag = "R10";
      else                                 tag = "R8";
      chk(tag, "mode", int'(mode), int'(VEC[i][3:1]));
      chk(tag, "pulse", int'(latch), int'(VEC[i][0]));
      chk_en("R2", VEC[i][3:1]);
    end

    // full mode x event sweep
    for (int s = 0; s < 5; s++) begin
      for (int e = 0; e < 7; e++) begin
        string tag;
        step(1'b1, E_NO);
        if (s >= 1) step(1'b0, E_EN);
        if (s == 2) step(1'b0, E_STA);
        if (s >= 3) step(1'b0, E_BRK);
        if (s == 4) step(1'b0, E_RES);
        step(1'b0, E_NO);
        chk("R2", "setup mode", int'(mode), s);
        ref_step(3'(s), 7'(1 << e), nm, rec);
        step(1'b0, 7'(1 << e));
        case (s)
          0: tag = "R3";
          1: tag = "R4";
          2: tag = "R5";
          3: tag = "R6";
          default: tag = "R7";
        endcase
        chk(tag, "mode", int'(mode), int'(nm));
        chk("R8", "pulse", int'(latch), int'(rec));
        chk_en("R2", nm);
        step(1'b0, E_NO);
        chk("R8", "pulse drop", int'(latch), 0);
        chk("R10", "hold mode", int'(mode), int'(nm));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule